// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes instructions for a stack machine in which no instruction names an operand. A register-based last-in-first-out store holds the operands. A push instruction places the value on the immediate input on top of the store. A pop instruction discards the top entry. Each binary arithmetic or logic instruction takes the two uppermost entries, combines them, and leaves a single result on top. Fetching instructions, memory traffic and code generation belong to the surrounding design.

The caller presents one instruction per cycle by raising `instr_stb` together with a 4-bit opcode, and with `push_data` when the opcode is a push. Every instruction takes effect at the next clock edge. The unit has no back-pressure: it can accept an instruction on every cycle, and for that reason it has no ready output. A one-cycle `done` pulse confirms each instruction, and `tos_out` then shows the new top entry. An instruction that would overflow or underflow the store leaves the store untouched and sets a sticky error flag. The depth of the store and the data width are parameters.

Top module: `stk_exec_unit`

## Requirements
- R1: A synchronous active-high reset empties the store and clears both error flags and `done`. While the store is empty, `tos_out` reads 0.
- R2: PUSH (opcode 1) on a store that is not full puts `push_data` on top and keeps every entry below it.
- R3: POP (opcode 2) on a store that is not empty removes the top entry, so that the entry below it becomes the top. Entries come back in the reverse of their push order.
- R4: DUP (opcode 3) on a store that is neither empty nor full pushes a copy of the current top.
- R5: The binary opcodes are ADD 4, SUB 5, AND 6, OR 7 and XOR 8. The entry second from the top is the left operand and the top entry is the right operand, so SUB computes second minus top. The result, truncated to DATA_W bits, replaces both entries, and occupancy falls by one. Entries further down are kept.
- R6: MUL (opcode 9) follows R5 and yields the low DATA_W bits of the product.
- R7: PUSH or DUP on a full store sets `overflow_flag` and leaves the contents unchanged.
- R8: POP or DUP on an empty store, or a binary opcode when fewer than two entries are held, sets `underflow_flag` and leaves the contents unchanged.
- R9: `done` is high in exactly the cycle after each cycle in which `instr_stb` is high. Back-to-back instructions are all executed.
- R10: Opcodes 0 and 10 to 15 change neither the store nor the flags, although `done` still pulses.
- R11: Once set, either error flag stays set until reset, whatever instructions follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_stb | input | 1 | An instruction is present this cycle |
| instr_op | input | 4 | Opcode |
| push_data | input | DATA_W | Value for PUSH |
| tos_out | output | DATA_W | Current top entry, or 0 when empty |
| done | output | 1 | Pulse: the previous cycle's instruction has completed |
| overflow_flag | output | 1 | Sticky: a PUSH or DUP found the store full |
| underflow_flag | output | 1 | Sticky: too few entries for an instruction |

## Verification
A wrong occupancy count shows up at once in `tos_out` after the instruction that corrupts it, because the top output is chosen from that count. It can also show up as an error flag raised one instruction early or late. A corrupted entry below the top stays hidden until enough pops or reductions bring it to the top. For that reason the sweeps fill the store and then drain it completely. The R5 checks also keep a third entry below the operands and read it back afterwards. Operand-order faults, such as swapped subtraction operands, or faults in truncation appear in the first result that follows the instruction.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_DUP  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_MUL  = 4'd9
  } stk_op_e;

  // change applied to the store in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_GROW   = 2'd1,
    ACT_SHRINK = 2'd2,
    ACT_REDUCE = 2'd3
  } stk_act_e;

  // where the written value comes from
  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_TOP = 2'd1,
    SRC_ALU = 2'd2
  } stk_src_e;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_MUL:  res = lhs * rhs;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             strobe,
  input  logic [3:0]       op,
  input  logic [CNT_W-1:0] level,
  output stk_act_e         act,
  output stk_src_e         src,
  output logic             ovf_hit,
  output logic             unf_hit
);

  logic is_full;
  logic is_empty;
  logic has_pair;

  assign is_full  = (level == CNT_W'(DEPTH));
  assign is_empty = (level == '0);
  assign has_pair = (level >= CNT_W'(2));

  always_comb begin
    act     = ACT_HOLD;
    src     = SRC_IMM;
    ovf_hit = 1'b0;
    unf_hit = 1'b0;
    if (strobe) begin
      unique case (op)
        OP_PUSH: begin
          if (is_full) ovf_hit = 1'b1;
          else act = ACT_GROW;
        end
        OP_POP: begin
          if (is_empty) unf_hit = 1'b1;
          else act = ACT_SHRINK;
        end
        OP_DUP: begin
          src = SRC_TOP;
          if (is_empty) unf_hit = 1'b1;
          else if (is_full) ovf_hit = 1'b1;
          else act = ACT_GROW;
        end
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_MUL: begin
          src = SRC_ALU;
          if (!has_pair) unf_hit = 1'b1;
          else act = ACT_REDUCE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stk_store.sv
module stk_store
  import stk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_act_e         act,
  input  logic [W-1:0]     wdata,
  output logic [CNT_W-1:0] level,
  output logic [W-1:0]     top,
  output logic [W-1:0]     second
);

  logic [W-1:0]     slot_q [DEPTH];
  logic [CNT_W-1:0] level_q;

  // one write port: a grow writes just above the top, a reduce writes into the second slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = ((act == ACT_GROW)   && (level_q == CNT_W'(g))) ||
                   ((act == ACT_REDUCE) && (level_q == CNT_W'(g + 2)));
    always_ff @(posedge clk) begin
      if (rst) slot_q[g] <= '0;
      else if (wr_en) slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else begin
      unique case (act)
        ACT_GROW:               level_q <= level_q + CNT_W'(1);
        ACT_SHRINK, ACT_REDUCE: level_q <= level_q - CNT_W'(1);
        default:                level_q <= level_q;
      endcase
    end
  end

  always_comb begin
    top    = '0;
    second = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level_q == CNT_W'(i + 1)) top    = slot_q[i];
      if (level_q == CNT_W'(i + 2)) second = slot_q[i];
    end
  end

  assign level = level_q;

endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_stb,
  input  logic [3:0]        instr_op,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] tos_out,
  output logic              done,
  output logic              overflow_flag,
  output logic              underflow_flag
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  stk_act_e          act;
  stk_src_e          src;
  logic              ovf_hit;
  logic              unf_hit;
  logic [CNT_W-1:0]  level;
  logic [DATA_W-1:0] top;
  logic [DATA_W-1:0] second;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] wdata;
  logic              done_q;
  logic              ovf_q;
  logic              unf_q;

  stk_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .strobe  (instr_stb),
    .op      (instr_op),
    .level   (level),
    .act     (act),
    .src     (src),
    .ovf_hit (ovf_hit),
    .unf_hit (unf_hit)
  );

  stk_alu #(.W(DATA_W)) u_alu (
    .op  (instr_op),
    .lhs (second),
    .rhs (top),
    .res (alu_res)
  );

  always_comb begin
    unique case (src)
      SRC_TOP: wdata = top;
      SRC_ALU: wdata = alu_res;
      default: wdata = push_data;
    endcase
  end

  stk_store #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .wdata  (wdata),
    .level  (level),
    .top    (top),
    .second (second)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      done_q <= instr_stb;
      ovf_q  <= ovf_q | ovf_hit;
      unf_q  <= unf_q | unf_hit;
    end
  end

  assign tos_out        = top;
  assign done           = done_q;
  assign overflow_flag  = ovf_q;
  assign underflow_flag = unf_q;

endmodule

// File: rtl/stk_exec_checker.sv
module stk_exec_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] imm,
  input logic [DATA_W-1:0] tos,
  input logic              done,
  input logic              ovf,
  input logic              unf,
  input logic [CNT_W-1:0]  level
);

  logic is_bin;
  logic is_undef;
  assign is_bin   = (op >= 4'd4) && (op <= 4'd9);
  assign is_undef = (op == 4'd0) || (op >= 4'd10);

  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe |=> done);
  a_r9_no_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !done);
  a_r2_push_lands_on_top: assert property (@(posedge clk) disable iff (rst)
    (strobe && op == 4'd1 && level < CNT_W'(DEPTH)) |=> (tos == $past(imm)));
  a_r7_overflow_holds_store: assert property (@(posedge clk) disable iff (rst)
    (strobe && (op == 4'd1 || op == 4'd3) && level == CNT_W'(DEPTH)) |=> (ovf && $stable(level) && $stable(tos)));
  a_r8_underflow_binop: assert property (@(posedge clk) disable iff (rst)
    (strobe && is_bin && level < CNT_W'(2)) |=> (unf && $stable(level) && $stable(tos)));
  a_r5_reduce_shrinks: assert property (@(posedge clk) disable iff (rst)
    (strobe && is_bin && level >= CNT_W'(2)) |=> (level == $past(level) - CNT_W'(1)));
  a_r10_undefined_no_effect: assert property (@(posedge clk) disable iff (rst)
    (strobe && is_undef) |=> ($stable(level) && $stable(tos) && $stable(ovf) && $stable(unf)));
  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r11_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    unf |=> unf);
  a_r1_level_bounded: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));

endmodule

bind stk_exec_unit stk_exec_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .strobe (instr_stb),
  .op     (instr_op),
  .imm    (push_data),
  .tos    (tos_out),
  .done   (done),
  .ovf    (overflow_flag),
  .unf    (underflow_flag),
  .level  (level)
);

// File: tb/stk_exec_unit_bench.sv
`timescale 1ns/1ps
module stk_exec_unit_bench;

  localparam int W  = 16;
  localparam int BD = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stb = 1'b0;
  logic [3:0]   op  = 4'd0;
  logic [W-1:0] din = '0;
  logic [W-1:0] tos;
  logic         done;
  logic         ovf;
  logic         unf;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0] m [BD];
  int           mcnt;
  logic         mo;
  logic         mu;

  always #2.5 clk = ~clk;

  stk_exec_unit #(.DATA_W(W), .DEPTH(BD)) u_stk_exec_unit (
    .clk            (clk),
    .rst            (rst),
    .instr_stb      (stb),
    .instr_op       (op),
    .push_data      (din),
    .tos_out        (tos),
    .done           (done),
    .overflow_flag  (ovf),
    .underflow_flag (unf)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_alu(input int o, input logic [W-1:0] a, input logic [W-1:0] b);
    longint la = longint'(a);
    longint lb = longint'(b);
    longint r;
    case (o)
      4: r = (la + lb) % 65536;
      5: r = (la - lb + 65536) % 65536;
      6: r = longint'(a & b);
      7: r = longint'(a | b);
      8: r = longint'(a ^ b);
      default: r = (la * lb) % 65536;
    endcase
    return W'(r);
  endfunction

  function automatic logic [W-1:0] mtop();
    return (mcnt == 0) ? '0 : m[mcnt-1];
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "tos", longint'(tos), longint'(mtop()));
    chk(tag, "overflow", longint'(ovf), longint'(mo));
    chk(tag, "underflow", longint'(unf), longint'(mu));
  endtask

  // caller is at a negedge; instruction is sampled at the next posedge
  task automatic run(input int o, input logic [W-1:0] v, input string tag);
    stb = 1'b1;
    op  = 4'(o);
    din = v;
    case (o)
      1: if (mcnt == BD) mo = 1'b1; else begin m[mcnt] = v; mcnt++; end
      2: if (mcnt == 0) mu = 1'b1; else mcnt--;
      3: if (mcnt == 0) mu = 1'b1;
         else if (mcnt == BD) mo = 1'b1;
         else begin m[mcnt] = m[mcnt-1]; mcnt++; end
      4, 5, 6, 7, 8, 9:
         if (mcnt < 2) mu = 1'b1;
         else begin m[mcnt-2] = ref_alu(o, m[mcnt-2], m[mcnt-1]); mcnt--; end
      default: ;
    endcase
    @(negedge clk);
    stb = 1'b0;
    chk(tag, "done pulse", longint'(done), 1);
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(tag, "done idle", longint'(done), 0);
    check_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcnt = 0;
    mo = 1'b0;
    mu = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] vals [8];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h0007;
    vals[4] = 16'h8000; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'h00FF;

    // R1: reset state
    do_reset();
    chk("R1", "done after reset", longint'(done), 0);
    check_all("R1");
    idle("R9");

    // R2, R3: LIFO order, empty reads zero
    run(1, 16'hAAAA, "R2");
    run(1, 16'h0B0B, "R2");
    run(1, 16'h00C3, "R2");
    run(2, '0, "R3");
    run(2, '0, "R3");
    run(2, '0, "R3");
    idle("R3");

    // R8 + R11: pop on empty, flag sticks through later good work
    run(2, '0, "R8");
    run(1, 16'h0042, "R11");
    run(2, '0, "R11");
    do_reset();
    check_all("R1");

    // R7: fill, overflow on push and dup, contents intact
    for (int i = 0; i < BD; i++) run(1, W'(16'h100 + i), "R2");
    run(1, 16'hDEAD, "R7");
    run(3, '0, "R7");
    for (int i = 0; i < BD; i++) run(2, '0, "R7");
    run(1, 16'h0005, "R11");
    do_reset();

    // R4: dup and dup on empty
    run(1, 16'h0777, "R4");
    run(3, '0, "R4");
    run(2, '0, "R4");
    run(2, '0, "R4");
    run(3, '0, "R8");
    do_reset();

    // R8: binary op with one entry
    run(1, 16'h0031, "R8");
    run(4, '0, "R8");
    run(9, '0, "R8");
    do_reset();

    // R10: undefined opcodes
    run(1, 16'h0055, "R10");
    run(0, 16'hFFFF, "R10");
    for (int o = 10; o < 16; o++) run(o, 16'hFFFF, "R10");
    run(2, '0, "R10");
    idle("R10");

    // R5, R6: operand sweep with a guard entry underneath
    run(1, 16'h5A5A, "R5");
    for (int o = 4; o <= 9; o++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          string t;
          t = (o == 9) ? "R6" : "R5";
          run(1, vals[a], t);
          run(1, vals[b], t);
          run(o, '0, t);
          run(2, '0, t);
        end
      end
    end
    run(2, '0, "R5");
    idle("R9");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule